// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a narrow port A and a wide port B, where port B is split into a low half and a high half, each as wide as port A. In the A-to-B direction, two narrow words that arrive one after the other are gathered and shown together as one wide word. The low-half path has two register stages and the high-half path has one, so the first word goes to the low half and the second word goes to the high half. In the B-to-A direction, each half of port B is captured in its own register, and a registered select picks which half drives port A.

Every data register loads on the rising clock edge only when its active-low load enable is low. The output enables and the half select are also registered, so a change of bus direction takes effect one clock later. A small control state machine holds the drive state of both ports. Its states are DIR_OFF (no port drives), DIR_A_ONLY, DIR_B_ONLY and DIR_BOTH. On every clock edge outside reset it moves to the state given by the two output-enable inputs: any state can go to any state. Reset forces DIR_OFF. Each pad is modelled as a data-out bus plus a drive flag instead of a tri-state net.

Top module: `bus_exchanger_nw`

## Requirements
- R1: A data register whose active-low load enable is high at a rising edge keeps its value, so the B outputs do not change while both A-side loads are high.
- R2: With `a_ld1_n` low, `a_in` is captured into the first stage of the low-half path only. The B outputs do not change at that edge.
- R3: With `a_ld2_n` low, at the same edge the high half (`b2_out`) takes `a_in` and the low half (`b1_out`) takes the first-stage content. A word loaded with `a_ld1_n` followed by a word loaded with `a_ld2_n` appears together on the B port after the second edge.
- R4: With both A-side loads low in one cycle, the low half takes the old first-stage word, and both the first stage and the high half take `a_in`.
- R5: `b1_ld_n` low captures `b1_in` and `b2_ld_n` low captures `b2_in`, each independently of the other.
- R6: `half_sel` is registered. A registered 0 routes the low-half capture to `a_out` and a registered 1 routes the high-half capture, one edge after the input changes.
- R7: `a_oe_n` and `b_oe_n` are registered. Each drive flag is the inverse of its enable as sampled at the previous edge.
- R8: While a drive flag is low, the data-out bus of that port is all zeros.
- R9: A synchronous active-high reset clears all data registers and the select, and forces both drive flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DATA_W | Narrow port, incoming data |
| a_out | output | DATA_W | Narrow port, outgoing data |
| a_drive | output | 1 | Narrow port drives when high |
| b1_in | input | DATA_W | Wide port low half, incoming |
| b2_in | input | DATA_W | Wide port high half, incoming |
| b1_out | output | DATA_W | Wide port low half, outgoing |
| b2_out | output | DATA_W | Wide port high half, outgoing |
| b_drive | output | 1 | Wide port drives when high |
| a_ld1_n | input | 1 | Loads first stage of low-half path (active low) |
| a_ld2_n | input | 1 | Loads high half and advances low-half path (active low) |
| b1_ld_n | input | 1 | Captures low half for port A (active low) |
| b2_ld_n | input | 1 | Captures high half for port A (active low) |
| half_sel | input | 1 | Half routed to port A: 0 low, 1 high |
| a_oe_n | input | 1 | Narrow port output enable (active low) |
| b_oe_n | input | 1 | Wide port output enable (active low) |

## Verification
The bench builds the block with the default DATA_W of 12. At this width, words such as all ones next to 0x001 exercise the top bit and the bottom bit of both halves, so a swapped or shifted half shows up directly. With the narrow width, every alignment case can be listed by hand: a staggered pair, both loads low in one cycle, and half select switching while only one half is recaptured.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    typedef enum logic [1:0] {
        DIR_OFF    = 2'b00,
        DIR_A_ONLY = 2'b01,
        DIR_B_ONLY = 2'b10,
        DIR_BOTH   = 2'b11
    } drive_state_e;

    function automatic drive_state_e dir_from_oe(input logic a_oe_n, input logic b_oe_n);
        drive_state_e d;
        unique case ({b_oe_n, a_oe_n})
            2'b11:   d = DIR_OFF;
            2'b10:   d = DIR_A_ONLY;
            2'b01:   d = DIR_B_ONLY;
            default: d = DIR_BOTH;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/xchg_en_reg.sv
module xchg_en_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!ld_n) begin
            q <= d;
        end
    end

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(q));
endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
    import xchg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_oe_n,
    input  logic b_oe_n,
    input  logic half_sel,
    output logic a_drive,
    output logic b_drive,
    output logic sel_hi
);
    drive_state_e state_q, state_d;

    always_comb begin
        state_d = dir_from_oe(a_oe_n, b_oe_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIR_OFF;
            sel_hi  <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_hi  <= half_sel;
        end
    end

    always_comb begin
        unique case (state_q)
            DIR_OFF:    begin a_drive = 1'b0; b_drive = 1'b0; end
            DIR_A_ONLY: begin a_drive = 1'b1; b_drive = 1'b0; end
            DIR_B_ONLY: begin a_drive = 1'b0; b_drive = 1'b1; end
            default:    begin a_drive = 1'b1; b_drive = 1'b1; end
        endcase
    end

    // R7: drive flags follow the enables one edge late
    a_r7_oe_delay: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (a_drive == !$past(a_oe_n)) && (b_drive == !$past(b_oe_n)));

    // R6: select follows its input one edge late
    a_r6_sel_delay: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sel_hi == $past(half_sel)));

    // R9: leaving reset, nothing drives
    a_r9_reset_off: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_drive && !b_drive && !sel_hi));
endmodule

// File: rtl/xchg_a2b.sv
module xchg_a2b #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         ld1_n,
    input  logic         ld2_n,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q
);
    logic [W-1:0] first_q;

    xchg_en_reg #(.W(W)) u_first (
        .clk(clk), .rst(rst), .ld_n(ld1_n), .d(a_in), .q(first_q)
    );
    xchg_en_reg #(.W(W)) u_lo (
        .clk(clk), .rst(rst), .ld_n(ld2_n), .d(first_q), .q(lo_q)
    );
    xchg_en_reg #(.W(W)) u_hi (
        .clk(clk), .rst(rst), .ld_n(ld2_n), .d(a_in), .q(hi_q)
    );

    // R3: second load aligns the staged word with the current word
    a_r3_pair_align: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> (hi_q == $past(a_in)) && (lo_q == $past(first_q)));

    // R2: a first-stage-only load leaves the wide outputs alone
    a_r2_first_only: assert property (@(posedge clk) disable iff (rst)
        (!ld1_n && ld2_n) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/xchg_b2a.sv
module xchg_b2a #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] hi_in,
    input  logic         lo_ld_n,
    input  logic         hi_ld_n,
    input  logic         sel_hi,
    output logic [W-1:0] pick
);
    logic [W-1:0] lo_cap, hi_cap;

    xchg_en_reg #(.W(W)) u_lo_cap (
        .clk(clk), .rst(rst), .ld_n(lo_ld_n), .d(lo_in), .q(lo_cap)
    );
    xchg_en_reg #(.W(W)) u_hi_cap (
        .clk(clk), .rst(rst), .ld_n(hi_ld_n), .d(hi_in), .q(hi_cap)
    );

    always_comb begin
        pick = sel_hi ? hi_cap : lo_cap;
    end

    // R5: each half captures its own input
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        !lo_ld_n |=> (lo_cap == $past(lo_in)));
    a_r5_capture_hi: assert property (@(posedge clk) disable iff (rst)
        !hi_ld_n |=> (hi_cap == $past(hi_in)));
endmodule

// File: rtl/bus_exchanger_nw.sv
module bus_exchanger_nw #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b1_in,
    input  logic [DATA_W-1:0] b2_in,
    output logic [DATA_W-1:0] b1_out,
    output logic [DATA_W-1:0] b2_out,
    output logic              b_drive,
    input  logic              a_ld1_n,
    input  logic              a_ld2_n,
    input  logic              b1_ld_n,
    input  logic              b2_ld_n,
    input  logic              half_sel,
    input  logic              a_oe_n,
    input  logic              b_oe_n
);
    localparam int WIDE_W = 2 * DATA_W;

    logic              sel_hi;
    logic [DATA_W-1:0] lo_q, hi_q, a_pick;
    logic [WIDE_W-1:0] wide_word;

    xchg_ctrl u_ctrl (
        .clk(clk), .rst(rst), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
        .half_sel(half_sel), .a_drive(a_drive), .b_drive(b_drive), .sel_hi(sel_hi)
    );

    xchg_a2b #(.W(DATA_W)) u_a2b (
        .clk(clk), .rst(rst), .a_in(a_in), .ld1_n(a_ld1_n), .ld2_n(a_ld2_n),
        .lo_q(lo_q), .hi_q(hi_q)
    );

    xchg_b2a #(.W(DATA_W)) u_b2a (
        .clk(clk), .rst(rst), .lo_in(b1_in), .hi_in(b2_in),
        .lo_ld_n(b1_ld_n), .hi_ld_n(b2_ld_n), .sel_hi(sel_hi), .pick(a_pick)
    );

    always_comb begin
        wide_word = b_drive ? {hi_q, lo_q} : '0;
        b1_out    = wide_word[DATA_W-1:0];
        b2_out    = wide_word[WIDE_W-1:DATA_W];
        a_out     = a_drive ? a_pick : '0;
    end

    // R8: an idle port shows zeros
    a_r8_quiet_a: assert property (@(posedge clk) disable iff (rst)
        !a_drive |-> (a_out == '0));
    a_r8_quiet_b: assert property (@(posedge clk) disable iff (rst)
        !b_drive |-> (b1_out == '0 && b2_out == '0));
endmodule

// File: tb/test_bus_exchanger_nw.sv
module test_bus_exchanger_nw;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         a_ld1_n = 1'b1, a_ld2_n = 1'b1, b1_ld_n = 1'b1, b2_ld_n = 1'b1;
    logic         half_sel = 1'b0, a_oe_n = 1'b1, b_oe_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drive, b_drive;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_exchanger_nw #(.DATA_W(W)) i_bus_exchanger_nw (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out),
        .b_drive(b_drive), .a_ld1_n(a_ld1_n), .a_ld2_n(a_ld2_n),
        .b1_ld_n(b1_ld_n), .b2_ld_n(b2_ld_n), .half_sel(half_sel),
        .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
    );

    typedef struct {
        string        req;
        logic [W-1:0] a, b1, b2;
        logic         ad, bd;
    } exp_t;
    exp_t sb[$];

    // reference state, built from the requirements
    logic [W-1:0] m_first = '0, m_lo = '0, m_hi = '0, m_cl = '0, m_ch = '0;
    logic         m_sel = 1'b0, m_ad = 1'b0, m_bd = 1'b0;

    task automatic step(input logic r, input logic [W-1:0] ai, input logic l1, input logic l2,
                        input logic [W-1:0] b1i, input logic [W-1:0] b2i,
                        input logic lb1, input logic lb2, input logic sel,
                        input logic aoe, input logic boe, input string req);
        exp_t e;
        logic [W-1:0] n_first, n_lo, n_hi;
        @(negedge clk);
        rst = r; a_in = ai; a_ld1_n = l1; a_ld2_n = l2;
        b1_in = b1i; b2_in = b2i; b1_ld_n = lb1; b2_ld_n = lb2;
        half_sel = sel; a_oe_n = aoe; b_oe_n = boe;
        if (r) begin
            m_first = '0; m_lo = '0; m_hi = '0; m_cl = '0; m_ch = '0;
            m_sel = 1'b0; m_ad = 1'b0; m_bd = 1'b0;
        end else begin
            n_first = l1 ? m_first : ai;
            n_lo    = l2 ? m_lo : m_first;
            n_hi    = l2 ? m_hi : ai;
            m_first = n_first; m_lo = n_lo; m_hi = n_hi;
            if (!lb1) m_cl = b1i;
            if (!lb2) m_ch = b2i;
            m_sel = sel; m_ad = !aoe; m_bd = !boe;
        end
        if (req != "") begin
            e.req = req;
            e.ad  = m_ad;
            e.bd  = m_bd;
            e.a   = m_ad ? (m_sel ? m_ch : m_cl) : '0;
            e.b1  = m_bd ? m_lo : '0;
            e.b2  = m_bd ? m_hi : '0;
            sb.push_back(e);
        end
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if ({a_out, b1_out, b2_out, a_drive, b_drive} !== {e.a, e.b1, e.b2, e.ad, e.bd}) begin
                    errors++;
                    $display("FAIL %s: actual a=%h b1=%h b2=%h ad=%b bd=%b expected a=%h b1=%h b2=%h ad=%b bd=%b",
                             e.req, a_out, b1_out, b2_out, a_drive, b_drive,
                             e.a, e.b1, e.b2, e.ad, e.bd);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset with enables asserted still leaves all quiet
        step(1, 12'h3C3, 0, 0, 12'h111, 12'h222, 0, 0, 1, 0, 0, "R9");
        step(1, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 0, 0, "R9");
        // R7: wide port enabled, one edge later it drives
        step(0, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R7");
        // R2 then R3: staggered pair
        step(0, 12'h123, 0, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R2");
        step(0, 12'hABC, 1, 0, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R3");
        // R1: no loads, inputs change, outputs hold
        step(0, 12'h9E7, 1, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R1");
        // R3: extreme pair
        step(0, 12'hFFF, 0, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R2");
        step(0, 12'h001, 1, 0, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R3");
        // R4: both loads low in one cycle
        step(0, 12'h555, 0, 0, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R4");
        step(0, 12'h0AA, 1, 0, 12'h000, 12'h000, 1, 1, 0, 1, 0, "R4");
        // R7/R8: wide port disabled
        step(0, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 1, 1, "R8");
        // R5: capture both halves, narrow port enabled, low half routed
        step(0, 12'h000, 1, 1, 12'h321, 12'h654, 0, 0, 0, 0, 1, "R5");
        // R6: switch to high half
        step(0, 12'h000, 1, 1, 12'hEEE, 12'hDDD, 1, 1, 1, 0, 1, "R6");
        // R5: recapture low half only while high is routed
        step(0, 12'h000, 1, 1, 12'h777, 12'h888, 0, 1, 1, 0, 1, "R5");
        step(0, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 0, 1, "R6");
        // R8: narrow port disabled
        step(0, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 1, 1, "R8");
        // R7: both ports on
        step(0, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 1, 0, 0, "R7");
        // R9: mid-run reset clears everything
        step(1, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 0, 0, "R9");
        step(0, 12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 0, 0, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule